// File: doc/BRIEF.md
# Multiply/Divide Issue Interlock Controller

This block decides, in every cycle, whether the integer pipeline has to hold its issuing instruction because of the multiply/divide unit. The decode stage gives it three things: a class code for the instruction waiting to issue, a flag from the multiplier saying that the operand is 32 bits wide, and a busy level from the iterative divider. From these it drives a pipeline stall and an accept strobe, and the accept strobe hands the instruction to the multiply/divide unit.

Inside, the block keeps four small countdown counters:
- a fixed-penalty counter for the multiply that writes a general register;
- a counter for the pending general-register result;
- a counter for the multiplier occupancy after a wide product;
- a counter for the pending HI/LO result.

The stall and the accept are combinational functions of these registered counters and of the current request. An instruction that was held is therefore accepted in the first cycle in which the stall falls. Arithmetic, forwarding and exceptions sit elsewhere.

Top module: `mdu_ilock`

## Requirements
- R1: After reset no counter is pending. With iss_valid low the stall is 0. Any instruction presented in the first cycle after reset issues without a stall.
- R2: The multiply classes are plain multiply (code 1), accumulate multiply (code 2) and register-writing multiply (code 3). When one of them is accepted with opnd_wide=1, a multiply class presented in the next cycle is held for exactly one cycle.
- R3: A multiply class accepted with opnd_wide=0 causes no stall for any following instruction, except the fixed penalty of code 3 (R6).
- R4: After a code 1 or code 2 multiply is accepted with opnd_wide=1, a HI/LO read (code 5) or accumulate multiply (code 2) presented next is held for one cycle.
- R5: The unit classes are codes 1 to 6. While div_busy is 1, and in the cycle right after a divide (code 4) is accepted, every unit class is held. Codes 0 and 7 are not held by this.
- R6: A register-writing multiply (code 3) accepted with opnd_wide=0 forces the stall high for the next cycle, whatever is presented, even with iss_valid low.
- R7: A register-writing multiply (code 3) accepted with opnd_wide=1 forces the stall high for the next two cycles.
- R8: A result-using integer op (code 7) that directly follows a code 3 multiply stalls one cycle more than the fixed penalty. If another instruction issues in between, code 7 then stalls 0 cycles.
- R9: A code 7 op presented right after an accepted HI/LO read (code 5) is held for one cycle.
- R10: mdu_accept = iss_valid, no stall, and a unit class (codes 1 to 6). It is never 1 together with the stall. It is never 1 for codes 0 and 7.
- R11: A HI/LO write (code 6) followed by any class causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is waiting to issue |
| iss_class | input | 3 | Class code of the waiting instruction (see R2 to R11) |
| opnd_wide | input | 1 | 1 when the multiply operand is 32 bits wide |
| div_busy | input | 1 | The iterative divider is working |
| stall | output | 1 | Hold the integer pipeline this cycle |
| mdu_accept | output | 1 | Instruction is handed to the multiply/divide unit this cycle |

## Verification
A counter that loads the wrong value, or fails to count down, shows up as a stall that is one cycle too long or too short. The error appears in the cycle right after the accept that loaded the counter. Because the bench sweeps every ordered pair of classes and widths from a clean reset, each miscounted penalty appears in a short, known window. A wrong unit-class decode shows up at once as an accept on a non-unit op, or as a missing accept.

// File: rtl/mdu_ilock_pkg.sv
package mdu_ilock_pkg;

   typedef enum logic [2:0] {
      CLS_NONE   = 3'd0,
      CLS_MULT   = 3'd1,
      CLS_MACC   = 3'd2,
      CLS_MULR   = 3'd3,
      CLS_DIV    = 3'd4,
      CLS_HLREAD = 3'd5,
      CLS_HLWR   = 3'd6,
      CLS_DEPINT = 3'd7
   } mdu_cls_e;

   function automatic logic cls_is_unit(input mdu_cls_e c);
      return (c != CLS_NONE) && (c != CLS_DEPINT);
   endfunction

   function automatic logic cls_is_mul(input mdu_cls_e c);
      return (c == CLS_MULT) || (c == CLS_MACC) || (c == CLS_MULR);
   endfunction

   function automatic logic cls_reads_hilo(input mdu_cls_e c);
      return (c == CLS_MACC) || (c == CLS_HLREAD);
   endfunction

endpackage

// File: rtl/mdu_ilock_cnt.sv
module mdu_ilock_cnt #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         busy
);

   logic [W-1:0] cnt_q, dec, cnt_d;

   always_comb begin
      dec   = (cnt_q != '0) ? cnt_q - W'(1) : '0;
      cnt_d = dec;
      if (load && (load_val > dec)) cnt_d = load_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign busy = (cnt_q != '0);

   // countdown never skips a value unless reloaded (supports R6, R7, R8)
   p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
   p_cnt_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/mdu_ilock_hazard.sv
module mdu_ilock_hazard
   import mdu_ilock_pkg::*;
(
   input  mdu_cls_e cls,
   input  logic     div_block,
   input  logic     gap_busy,
   input  logic     hilo_busy,
   input  logic     gpr_busy,
   output logic     hazard,
   output logic     unit_cls
);

   logic h_div, h_gap, h_hilo, h_gpr;

   always_comb begin
      unit_cls = cls_is_unit(cls);
      h_div    = unit_cls && div_block;
      h_gap    = cls_is_mul(cls) && gap_busy;
      h_hilo   = cls_reads_hilo(cls) && hilo_busy;
      h_gpr    = (cls == CLS_DEPINT) && gpr_busy;
      hazard   = h_div | h_gap | h_hilo | h_gpr;
   end

   // non-unit ops never see the divider hazard (R5)
   always_comb begin
      if (!unit_cls) a_div_scope_r5: assert (!h_div);
   end

endmodule

// File: rtl/mdu_ilock.sv
module mdu_ilock
   import mdu_ilock_pkg::*;
#(
   parameter int FIX_SHORT   = 1,
   parameter int FIX_LONG    = 2,
   parameter int DEP_EXTRA   = 1,
   parameter int WIDE_GAP    = 1,
   parameter int HILO_LAT_WD = 2,
   parameter int MOVE_LAT    = 2,
   parameter bit DIV_ARM     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       iss_valid,
   input  logic [2:0] iss_class,
   input  logic       opnd_wide,
   input  logic       div_busy,
   output logic       stall,
   output logic       mdu_accept
);

   localparam int MAXV  = FIX_LONG + DEP_EXTRA + WIDE_GAP + HILO_LAT_WD + MOVE_LAT;
   localparam int CNT_W = $clog2(MAXV + 1);

   if (FIX_SHORT < 1 || FIX_LONG < FIX_SHORT) begin : g_bad_fix
      $error("mdu_ilock: fixed penalties must satisfy 1 <= FIX_SHORT <= FIX_LONG");
   end
   if (DEP_EXTRA < 0 || WIDE_GAP < 0) begin : g_bad_extra
      $error("mdu_ilock: extra stall counts must be non-negative");
   end
   if (HILO_LAT_WD < 1 || MOVE_LAT < 1) begin : g_bad_lat
      $error("mdu_ilock: latencies must be at least 1");
   end

   mdu_cls_e cls;
   logic     unit_cls, hazard;
   logic     fix_busy, gpr_busy, gap_busy, hilo_busy, div_block;
   logic     acc_mulr, acc_wide_mul, acc_wide_hilo, acc_read;
   logic [CNT_W-1:0] fix_val, gpr_val, gap_val, hilo_val;

   assign cls = mdu_cls_e'(iss_class);

   mdu_ilock_hazard u_haz (
      .cls       (cls),
      .div_block (div_block),
      .gap_busy  (gap_busy),
      .hilo_busy (hilo_busy),
      .gpr_busy  (gpr_busy),
      .hazard    (hazard),
      .unit_cls  (unit_cls)
   );

   assign stall      = fix_busy | (iss_valid & hazard);
   assign mdu_accept = iss_valid & ~stall & unit_cls;

   always_comb begin
      acc_mulr      = mdu_accept && (cls == CLS_MULR);
      acc_wide_mul  = mdu_accept && opnd_wide && cls_is_mul(cls);
      acc_wide_hilo = mdu_accept && opnd_wide && ((cls == CLS_MULT) || (cls == CLS_MACC));
      acc_read      = mdu_accept && (cls == CLS_HLREAD);
      fix_val  = opnd_wide ? CNT_W'(FIX_LONG) : CNT_W'(FIX_SHORT);
      gpr_val  = acc_mulr ? CNT_W'(fix_val + CNT_W'(DEP_EXTRA)) : CNT_W'(MOVE_LAT - 1);
      gap_val  = CNT_W'(WIDE_GAP);
      hilo_val = CNT_W'(HILO_LAT_WD - 1);
   end

   mdu_ilock_cnt #(.W(CNT_W)) u_fix (
      .clk(clk), .rst_n(rst_n), .load(acc_mulr), .load_val(fix_val), .busy(fix_busy));
   mdu_ilock_cnt #(.W(CNT_W)) u_gpr (
      .clk(clk), .rst_n(rst_n), .load(acc_mulr | acc_read), .load_val(gpr_val), .busy(gpr_busy));
   mdu_ilock_cnt #(.W(CNT_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(acc_wide_mul), .load_val(gap_val), .busy(gap_busy));
   mdu_ilock_cnt #(.W(CNT_W)) u_hilo (
      .clk(clk), .rst_n(rst_n), .load(acc_wide_hilo), .load_val(hilo_val), .busy(hilo_busy));

   if (DIV_ARM) begin : g_div_arm
      logic arm_q;
      always_ff @(posedge clk) begin
         if (!rst_n) arm_q <= 1'b0;
         else        arm_q <= mdu_accept && (cls == CLS_DIV);
      end
      assign div_block = div_busy | arm_q;
   end else begin : g_div_direct
      assign div_block = div_busy;
   end

   // accept only when issuing, not stalled (R10)
   p_acc_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mdu_accept |-> (iss_valid && !stall));
   p_acc_unit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_class == 3'd0 || iss_class == 3'd7) |-> !mdu_accept);
   p_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      div_busy |-> !mdu_accept);
   p_mulr_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mdu_accept && iss_class == 3'd3) |=> stall);
   p_mulr_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mdu_accept && iss_class == 3'd3 && opnd_wide) |=> stall ##1 stall);
   p_wide_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mdu_accept && opnd_wide && iss_class >= 3'd1 && iss_class <= 3'd3)
      |=> !(mdu_accept && iss_class >= 3'd1 && iss_class <= 3'd3));
   p_read_dep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mdu_accept && iss_class == 3'd5) |=> !(iss_valid && iss_class == 3'd7 && !stall));

endmodule

// File: tb/mdu_ilock_tb_top.sv
module mdu_ilock_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       iss_valid = 1'b0;
   logic [2:0] iss_class = 3'd0;
   logic       opnd_wide = 1'b0;
   logic       div_busy = 1'b0;
   logic       stall, mdu_accept;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdu_ilock dut_i (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
      .opnd_wide(opnd_wide), .div_busy(div_busy), .stall(stall), .mdu_accept(mdu_accept));

   function automatic bit is_unit(input int c);
      return (c >= 1 && c <= 6);
   endfunction
   function automatic bit is_mul(input int c);
      return (c >= 1 && c <= 3);
   endfunction

   // expected stall cycles of the second op, presented right after the first
   function automatic int exp_stall(input int c1, input bit w1, input int c2);
      if (c1 == 3) return (w1 ? 2 : 1) + ((c2 == 7) ? 1 : 0);
      if (is_mul(c1) && w1 && is_mul(c2)) return 1;
      if ((c1 == 1 || c1 == 2) && w1 && c2 == 5) return 1;
      if (c1 == 5 && c2 == 7) return 1;
      if (c1 == 4 && is_unit(c2)) return 1;
      return 0;
   endfunction

   function automatic string tag_of(input int c1, input bit w1, input int c2);
      if (c1 == 3) return (c2 == 7) ? "R8" : (w1 ? "R7" : "R6");
      if (is_mul(c1) && w1 && (is_mul(c2) || c2 == 5)) return is_mul(c2) ? "R2" : "R4";
      if (c1 == 5 && c2 == 7) return "R9";
      if (c1 == 4) return "R5";
      if (c1 == 6) return "R11";
      if (is_mul(c1)) return "R3";
      return "R1";
   endfunction

   task automatic check(input string req, input int act, input int expv, input string what);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic do_reset();
      iss_valid = 1'b0; div_busy = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // presents an op at the current negedge; returns stall cycles until it goes
   task automatic present(input int c, input bit w, output int n, output bit acc);
      iss_valid = 1'b1; iss_class = 3'(c); opnd_wide = w;
      n = 0;
      #1;
      while (stall && n < 9) begin
         n++;
         @(negedge clk);
         #1;
      end
      acc = mdu_accept;
   endtask

   task automatic run_pair(input int c1, input bit w1, input int c2, input bit w2);
      int n; bit acc;
      string t;
      do_reset();
      present(c1, w1, n, acc);
      check("R1", n, 0, "first op stall after reset");
      check("R10", int'(acc), int'(is_unit(c1)), "accept of first op");
      @(negedge clk);
      present(c2, w2, n, acc);
      t = tag_of(c1, w1, c2);
      check(t, n, exp_stall(c1, w1, c2), $sformatf("stall cls %0d/%0d then %0d", c1, w1, c2));
      check("R10", int'(acc), int'(is_unit(c2)), "accept of second op");
      @(negedge clk);
      iss_valid = 1'b0;
   endtask

   initial begin
      int n; bit acc;
      do_reset();
      #1;
      check("R1", int'(stall), 0, "stall idle after reset");
      check("R1", int'(mdu_accept), 0, "accept idle after reset");

      for (int c1 = 0; c1 < 8; c1++)
         for (int w1 = 0; w1 < 2; w1++)
            for (int c2 = 0; c2 < 8; c2++)
               for (int w2 = 0; w2 < 2; w2++)
                  run_pair(c1, w1[0], c2, w2[0]);

      // R6/R7: fixed penalty with no follower presented
      for (int w = 0; w < 2; w++) begin
         int cnt;
         do_reset();
         present(3, w[0], n, acc);
         @(negedge clk);
         iss_valid = 1'b0;
         cnt = 0;
         for (int k = 0; k < 4; k++) begin
            #1;
            if (stall) cnt++;
            @(negedge clk);
         end
         check(w ? "R7" : "R6", cnt, w ? 2 : 1, "idle stall cycles after register multiply");
      end

      // R8: intervening op removes the extra dependency stall
      do_reset();
      present(3, 1'b0, n, acc);
      @(negedge clk);
      present(0, 1'b0, n, acc);
      check("R8", n, 1, "plain op after register multiply");
      @(negedge clk);
      present(7, 1'b0, n, acc);
      check("R8", n, 0, "dependent op one instruction later");
      @(negedge clk);
      iss_valid = 1'b0;

      // R5: divider busy holds unit ops only
      for (int c = 0; c < 8; c++) begin
         do_reset();
         div_busy = 1'b1;
         iss_valid = 1'b1; iss_class = 3'(c); opnd_wide = 1'b0;
         #1;
         check("R5", int'(stall), int'(is_unit(c)), $sformatf("stall cls %0d while divider busy", c));
         check("R5", int'(mdu_accept), 0, "no accept while divider busy");
         repeat (3) @(negedge clk);
         div_busy = 1'b0;
         #1;
         check("R5", int'(mdu_accept), int'(is_unit(c)), "accept once divider idle");
         @(negedge clk);
         iss_valid = 1'b0;
      end

      // R5: divide followed by external busy window
      do_reset();
      present(4, 1'b0, n, acc);
      @(negedge clk);
      div_busy = 1'b1;
      fork
         begin
            repeat (5) @(negedge clk);
            div_busy = 1'b0;
         end
         present(1, 1'b0, n, acc);
      join
      check("R5", n, 5, "multiply held through divide");
      check("R10", int'(acc), 1, "multiply accepted after divide");
      @(negedge clk);
      iss_valid = 1'b0;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule